// File: doc/BRIEF.md
# Return-to-Zero to Level-Encoded Two-Phase Output Converter

This block sits at the output of a function block that computes in four-phase dual-rail code. It turns each result bit, given as a true rail and a false rail, into a level-encoded two-phase pair: a value wire and a parity wire. The next node sees exactly one wire change per bit for each new result. Each bit's value wire follows whichever of its rails rose. The parity wire then carries the value wire, or its inverse, depending on the phase of the input word that started the computation. While the function block passes through its spacer (both rails low), the outputs keep their values. As a result, the two-phase side never sees the return to zero.

The input phase reaches the parity logic through a holding register that samples only while the function block's completion signal is low. A new input word that arrives while the block is still evaluating or resetting cannot disturb the parity of the result being sent. Every bit converts on its own as soon as its pair evaluates. The per-bit phases (value XOR parity) are merged into a single output phase that changes only when every bit agrees. A pair with both rails high is illegal and raises an error flag.

The design is a clocked model with a synchronous active-high reset. Rails are sampled on the rising clock edge, and every output is registered.

Top module: `rz_to_ledr_out`

## Requirements
- R1: A bit whose true rail is high and false rail is low shows value wire 1 one clock edge later.
- R2: A bit whose false rail is high and true rail is low shows value wire 0 one clock edge later.
- R3: While both rails of a bit are low (spacer), its value and parity wires keep their previous values.
- R4: When a bit evaluates, its parity wire becomes equal to its value wire if the held phase is 0 (even), and becomes its inverse if the held phase is 1 (odd).
- R5: The held phase takes the value of the phase input at each clock edge where the completion input is low. At an edge where completion is high, the held phase keeps its value, so parity uses the older phase.
- R6: Each bit updates from its own pair only. A bit in spacer keeps its wires while other bits of the word evaluate.
- R7: A pair with both rails high leaves that bit's value and parity unchanged and drives the error output to 1 one edge later. The error output is 0 at edges where no pair has both rails high.
- R8: The output phase becomes 1 when every bit has value XOR parity equal to 1, and 0 when every bit has it equal to 0, one edge after the value and parity wires settle. With mixed bits, it holds its value.
- R9: After reset, all value wires, parity wires, the output phase, the held phase and the error output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_t | input | WIDTH | True rails of the dual-rail result |
| rail_f | input | WIDTH | False rails of the dual-rail result |
| in_phase | input | 1 | Phase of the two-phase input word (0 even, 1 odd) |
| blk_done | input | 1 | Function-block completion (high after evaluate, low after reset) |
| lv_data | output | WIDTH | Level-encoded value wires |
| lv_par | output | WIDTH | Level-encoded parity wires |
| out_phase | output | 1 | Merged phase of the output word |
| rail_err | output | 1 | Some pair had both rails high |

## Verification
A wrong held phase shows on the parity wires at the first evaluation after the fault: every bit then carries the inverse of the expected parity, one edge after the rails rise. A value or parity register that leaks during spacer shows as a change at the ports in the same spacer cycle. A merge stage that does not wait for agreement switches the output phase in a partially converted word, one edge after the mixed state appears. That is the window the partial-update scenario watches.

// File: rtl/rzl_pkg.sv
package rzl_pkg;
  // rail pair code, packed as {true, false}
  typedef enum logic [1:0] {
    RAIL_NULL = 2'b00,
    RAIL_ZERO = 2'b01,
    RAIL_ONE  = 2'b10,
    RAIL_BAD  = 2'b11
  } rail_code_t;

  localparam logic PH_EVEN = 1'b0;
  localparam logic PH_ODD  = 1'b1;
endpackage

// File: rtl/rzl_phase_hold.sv
module rzl_phase_hold (
  input  logic clk,
  input  logic rst,
  input  logic in_phase,
  input  logic blk_done,
  output logic ph_q
);
  always_ff @(posedge clk) begin
    if (rst)            ph_q <= rzl_pkg::PH_EVEN;
    else if (!blk_done) ph_q <= in_phase;
  end

  AST_PH_FROZEN: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> $stable(ph_q)); // R5
  AST_PH_TRACK: assert property (@(posedge clk) disable iff (rst)
    !blk_done |=> ph_q == $past(in_phase)); // R5
endmodule

// File: rtl/rzl_bit_cell.sv
module rzl_bit_cell
  import rzl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic t_in,
  input  logic f_in,
  input  logic ph,
  output logic d_q,
  output logic p_q,
  output logic bad
);
  rail_code_t code;
  logic       eval;
  logic       nxt_d;

  assign code  = rail_code_t'({t_in, f_in});
  assign eval  = (code == RAIL_ONE) || (code == RAIL_ZERO);
  assign nxt_d = (code == RAIL_ONE);
  assign bad   = (code == RAIL_BAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= 1'b0;
      p_q <= 1'b0;
    end else if (eval) begin
      d_q <= nxt_d;
      p_q <= nxt_d ^ ph;
    end
  end

  AST_SET_ONE: assert property (@(posedge clk) disable iff (rst)
    (t_in && !f_in) |=> d_q); // R1
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (f_in && !t_in) |=> !d_q); // R2
  AST_SPACER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!t_in && !f_in) |=> ($stable(d_q) && $stable(p_q))); // R3
  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (rst)
    ((t_in ^ f_in) && ph == PH_EVEN) |=> (p_q == d_q)); // R4
  AST_PAR_ODD: assert property (@(posedge clk) disable iff (rst)
    ((t_in ^ f_in) && ph == PH_ODD) |=> (p_q != d_q)); // R4
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (t_in && f_in) |=> ($stable(d_q) && $stable(p_q))); // R7
endmodule

// File: rtl/rzl_phase_merge.sv
module rzl_phase_merge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] bit_ph,
  output logic             ph_out
);
  logic all_one, all_zero;
  assign all_one  = &bit_ph;
  assign all_zero = ~|bit_ph;

  always_ff @(posedge clk) begin
    if (rst)           ph_out <= 1'b0;
    else if (all_one)  ph_out <= 1'b1;
    else if (all_zero) ph_out <= 1'b0;
  end

  AST_MERGE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_out) |-> $past(&bit_ph)); // R8
  AST_MERGE_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(ph_out) |-> $past(bit_ph == '0)); // R8
endmodule

// File: rtl/rz_to_ledr_out.sv
module rz_to_ledr_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  input  logic             in_phase,
  input  logic             blk_done,
  output logic [WIDTH-1:0] lv_data,
  output logic [WIDTH-1:0] lv_par,
  output logic             out_phase,
  output logic             rail_err
);
  logic             ph_held;
  logic [WIDTH-1:0] bad_vec;
  logic [WIDTH-1:0] bit_ph;

  rzl_phase_hold u_hold (
    .clk(clk), .rst(rst), .in_phase(in_phase), .blk_done(blk_done), .ph_q(ph_held)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    rzl_bit_cell u_cell (
      .clk(clk), .rst(rst), .t_in(rail_t[i]), .f_in(rail_f[i]), .ph(ph_held),
      .d_q(lv_data[i]), .p_q(lv_par[i]), .bad(bad_vec[i])
    );
  end

  assign bit_ph = lv_data ^ lv_par;

  rzl_phase_merge #(.WIDTH(WIDTH)) u_merge (
    .clk(clk), .rst(rst), .bit_ph(bit_ph), .ph_out(out_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) rail_err <= 1'b0;
    else     rail_err <= |(rail_t & rail_f);
  end

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((rail_t & rail_f) != '0) |=> rail_err); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((rail_t & rail_f) == '0) |=> !rail_err); // R7
endmodule

// File: tb/sim_rz_to_ledr_out.sv
module sim_rz_to_ledr_out;
  localparam int W = 8;
  localparam time PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] rail_t = '0, rail_f = '0;
  logic         in_phase = 1'b0, blk_done = 1'b0;
  logic [W-1:0] lv_data, lv_par;
  logic         out_phase, rail_err;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  rz_to_ledr_out #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .rail_t(rail_t), .rail_f(rail_f),
    .in_phase(in_phase), .blk_done(blk_done),
    .lv_data(lv_data), .lv_par(lv_par), .out_phase(out_phase), .rail_err(rail_err)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, pass one posedge, return at next negedge
  task automatic step(input logic [W-1:0] t, input logic [W-1:0] f);
    rail_t = t; rail_f = f;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic word(input logic [W-1:0] v);
    step(v, ~v);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "data", lv_data, '0);
    chk("R9", "par", lv_par, '0);
    chk("R9", "phase", {7'd0, out_phase}, '0);
    chk("R9", "err", {7'd0, rail_err}, '0);
  endtask

  task automatic t_even;
    in_phase = 1'b0; blk_done = 1'b0;
    word(8'hA5);
    chk("R1", "data ones", lv_data & 8'hA5, 8'hA5);
    chk("R2", "data zeros", lv_data & 8'h5A, 8'h00);
    chk("R4", "even parity", lv_par, 8'hA5);
    blk_done = 1'b1;
    step('0, '0);
    chk("R3", "spacer data", lv_data, 8'hA5);
    chk("R3", "spacer par", lv_par, 8'hA5);
    chk("R8", "phase even", {7'd0, out_phase}, 8'h00);
  endtask

  task automatic t_odd;
    blk_done = 1'b0; in_phase = 1'b1;
    step('0, '0);
    word(8'h3C);
    chk("R4", "odd data", lv_data, 8'h3C);
    chk("R4", "odd parity", lv_par, 8'hC3);
    step('0, '0);
    chk("R8", "phase odd", {7'd0, out_phase}, 8'h01);
  endtask

  task automatic t_latch;
    blk_done = 1'b1; in_phase = 1'b0;
    step('0, '0);
    word(8'hF0);
    chk("R5", "old phase kept", lv_par, 8'h0F);
    blk_done = 1'b0;
    step('0, '0);
    word(8'h0F);
    chk("R5", "new phase used", lv_par, 8'h0F);
    step('0, '0);
    chk("R8", "phase back even", {7'd0, out_phase}, 8'h00);
  endtask

  task automatic t_partial;
    in_phase = 1'b1;
    step('0, '0);
    step(8'h00, 8'h0F);
    chk("R6", "low nibble data", lv_data, 8'h00);
    chk("R6", "upper held par", lv_par, 8'h0F);
    step('0, '0);
    chk("R8", "mixed holds", {7'd0, out_phase}, 8'h00);
    step(8'h00, 8'hF0);
    chk("R6", "upper par", lv_par, 8'hFF);
    step('0, '0);
    chk("R8", "all agree odd", {7'd0, out_phase}, 8'h01);
  endtask

  task automatic t_err;
    step(8'h01, 8'h01);
    chk("R7", "err set", {7'd0, rail_err}, 8'h01);
    chk("R7", "data held", lv_data, 8'h00);
    chk("R7", "par held", lv_par, 8'hFF);
    step('0, '0);
    chk("R7", "err clear", {7'd0, rail_err}, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_even();
    t_odd();
    t_latch();
    t_partial();
    t_err();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule